// File: doc/BRIEF.md
# Cascadable Column Grayscale Sampler

This block collects one display line of grayscale data for a column driver. Three 6-bit words arrive in parallel on every clock, one for each channel group (A, B and C). The block keeps them in a sampling store of 80 slots with three words per slot. A line starts when an enable is seen while the block is idle. A slot pointer then walks the store in ascending or descending order, as the direction select chooses. After 80 writes the block returns to standby.

Several blocks form a chain. Each one raises a one-cycle hand-off pulse just before its last write, and that pulse drives the enable of the next block. The next block then takes the very next data word, so there is no gap in the stream.

On a pad, the two enable pins swap roles with the direction select. Here each pin is modelled as a separate input port and output port. The whole sampling store is presented as one flat vector for the downstream load stage.

Top module: `col_sample_ctrl`

## Requirements
- R1: While idle, a high on the currently active enable input is captured on a rising edge, and the first data word is written on the next rising edge.
- R2: Each transfer writes the three words into one slot. Slot s (slot 1 is s=0) and channel c (A=0, B=1, C=2) occupy bits [(s*3+c)*6 +: 6] of `samples`. Each word is stored as plain binary, so bit 5 weighs 32 and bit 0 weighs 1.
- R3: A line is exactly 80 transfers. After the last one the block is in standby, and changing data causes no further writes.
- R4: With `dir_up` high the slots are written 1, 2, …, 80. With `dir_up` low they are written 80, 79, …, 1.
- R5: The hand-off output rises on the edge one period before the final slot is written. It stays high for exactly one period.
- R6: With `dir_up` high, `en_fwd_in` is the enable input and `en_rev_out` carries the hand-off. In that case `en_rev_in` is ignored and `en_fwd_out` stays low. With `dir_up` low the roles are mirrored.
- R7: An enable that arrives during a transfer is ignored. The line neither restarts nor stretches.
- R8: A synchronous active-high reset returns the block to standby. It clears the slot pointer, drops both hand-off outputs and zeroes the sampling store.
- R9: When two blocks are chained through the hand-off, the downstream block writes its first slot on the edge right after the upstream block writes its last slot. This holds in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Slot order and enable pin role select; must be held static during a line |
| en_fwd_in | input | 1 | Enable input when `dir_up` is high |
| en_rev_in | input | 1 | Enable input when `dir_up` is low |
| en_fwd_out | output | 1 | Hand-off output when `dir_up` is low, else 0 |
| en_rev_out | output | 1 | Hand-off output when `dir_up` is high, else 0 |
| d_a | input | 6 | Channel A grayscale word |
| d_b | input | 6 | Channel B grayscale word |
| d_c | input | 6 | Channel C grayscale word |
| samples | output | 1440 | Flattened sampling store, layout per R2 |

## Verification
Two blocks are chained, and full 160-word lines are driven through them in both directions. The data patterns are chosen so that each one exposes a different class of fault:

- A slowly rising ramp with a different offset per channel reveals a swapped channel group, a reversed slot order, or a downstream block that starts one word early or late.
- A constant all-ones line followed by an all-zero line confirms that every bit position and every slot is actually rewritten.
- Steeper ramps reveal bit-weight errors.

Extra enable pulses arrive during a line, including on the final write edge. A reset is applied mid-line. The unused enable pin is toggled while the block is idle. In each of these cases the store must not change and the hand-off outputs must not move.

// File: rtl/col_samp_pkg.sv
package col_samp_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_XFER = 1'b1
    } phase_e;

    localparam int unsigned GROUPS = 3;

endpackage

// File: rtl/col_slot_seq.sv
module col_slot_seq
    import col_samp_pkg::*;
#(
    parameter int unsigned SLOTS = 80,
    parameter int unsigned CW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_up,
    input  logic          arm_in,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output logic          we,
    output logic [CW-1:0] widx,
    output logic          casc
);

    localparam logic [CW-1:0] LAST     = CW'(SLOTS - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(SLOTS - 2);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          casc;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.casc = 1'b0;
        we       = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (arm_in) begin
                    s_d.ph  = PH_XFER;
                    s_d.cnt = '0;
                end
            end
            PH_XFER: begin
                we = 1'b1;
                if (s_q.cnt == LAST) begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
                // pulse lands on the edge that also writes slot LAST-1
                s_d.casc = (s_q.cnt == PRE_LAST);
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, casc: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.ph == PH_XFER);
    assign cnt  = s_q.cnt;
    assign casc = s_q.casc;
    assign widx = dir_up ? s_q.cnt : (LAST - s_q.cnt);

endmodule

// File: rtl/col_slot_bank.sv
module col_slot_bank #(
    parameter int unsigned SLOTS = 80,
    parameter int unsigned CH    = 3,
    parameter int unsigned DW    = 6,
    parameter int unsigned CW    = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [CW-1:0]             widx,
    input  logic [CH*DW-1:0]          wdata,
    output logic [SLOTS*CH*DW-1:0]    flat
);

    localparam int unsigned ROW = CH * DW;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [ROW-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (we && (widx == CW'(s))) begin
                row_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else begin
                row_q <= row_d;
            end
        end

        assign flat[s*ROW +: ROW] = row_q;
    end

endmodule

// File: rtl/col_casc_route.sv
module col_casc_route (
    input  logic dir_up,
    input  logic en_fwd_in,
    input  logic en_rev_in,
    input  logic casc,
    output logic arm_in,
    output logic en_fwd_out,
    output logic en_rev_out
);

    always_comb begin
        arm_in     = dir_up ? en_fwd_in : en_rev_in;
        en_rev_out = dir_up & casc;
        en_fwd_out = ~dir_up & casc;
    end

endmodule

// File: rtl/col_sample_ctrl.sv
module col_sample_ctrl
    import col_samp_pkg::*;
#(
    parameter int unsigned SLOTS = 80,
    parameter int unsigned DW    = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         dir_up,
    input  logic                         en_fwd_in,
    input  logic                         en_rev_in,
    output logic                         en_fwd_out,
    output logic                         en_rev_out,
    input  logic [DW-1:0]                d_a,
    input  logic [DW-1:0]                d_b,
    input  logic [DW-1:0]                d_c,
    output logic [SLOTS*GROUPS*DW-1:0]   samples
);

    localparam int unsigned CW = $clog2(SLOTS);

    logic          arm_in;
    logic          busy;
    logic [CW-1:0] cnt;
    logic          we;
    logic [CW-1:0] widx;
    logic          casc;

    col_casc_route u_route (
        .dir_up     (dir_up),
        .en_fwd_in  (en_fwd_in),
        .en_rev_in  (en_rev_in),
        .casc       (casc),
        .arm_in     (arm_in),
        .en_fwd_out (en_fwd_out),
        .en_rev_out (en_rev_out)
    );

    col_slot_seq #(.SLOTS(SLOTS), .CW(CW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .dir_up (dir_up),
        .arm_in (arm_in),
        .busy   (busy),
        .cnt    (cnt),
        .we     (we),
        .widx   (widx),
        .casc   (casc)
    );

    col_slot_bank #(.SLOTS(SLOTS), .CH(GROUPS), .DW(DW), .CW(CW)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .widx  (widx),
        .wdata ({d_c, d_b, d_a}),
        .flat  (samples)
    );

endmodule

// File: rtl/col_sample_chk.sv
module col_sample_chk #(
    parameter int unsigned SLOTS = 80,
    parameter int unsigned CW    = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst,
    input logic          dir_up,
    input logic          arm_in,
    input logic          busy,
    input logic [CW-1:0] cnt,
    input logic          casc,
    input logic          en_fwd_out,
    input logic          en_rev_out
);

    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    p_arm_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && arm_in) |=> (busy && cnt == '0));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST));

    p_line_end_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST) |=> !busy);

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + CW'(1)));

    p_casc_pos_r5: assert property (@(posedge clk) disable iff (rst)
        casc |-> (busy && cnt == LAST));

    p_casc_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (en_fwd_out || en_rev_out) |=> !(en_fwd_out || en_rev_out));

    p_pin_role_r6: assert property (@(posedge clk) disable iff (rst)
        dir_up ? !en_fwd_out : !en_rev_out);

endmodule

bind col_sample_ctrl col_sample_chk #(.SLOTS(SLOTS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir_up     (dir_up),
    .arm_in     (arm_in),
    .busy       (busy),
    .cnt        (cnt),
    .casc       (casc),
    .en_fwd_out (en_fwd_out),
    .en_rev_out (en_rev_out)
);

// File: tb/test_col_sample_ctrl.sv
`timescale 1ns/1ps
module test_col_sample_ctrl;

    localparam int SLOTS = 80;
    localparam int DW    = 6;
    localparam int FW    = SLOTS * 3 * DW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_up = 1'b1;
    logic en_f0 = 1'b0, en_r0 = 1'b0;
    logic [DW-1:0] d_a = '0, d_b = '0, d_c = '0;
    logic fo0, ro0, fo1, ro1;
    logic [FW-1:0] smp0, smp1;

    logic [DW-1:0] exp0 [SLOTS*3];
    logic [DW-1:0] exp1 [SLOTS*3];

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    col_sample_ctrl #(.SLOTS(SLOTS), .DW(DW)) i_col_sample_ctrl (
        .clk(clk), .rst(rst), .dir_up(dir_up),
        .en_fwd_in(en_f0), .en_rev_in(en_r0),
        .en_fwd_out(fo0), .en_rev_out(ro0),
        .d_a(d_a), .d_b(d_b), .d_c(d_c), .samples(smp0));

    col_sample_ctrl #(.SLOTS(SLOTS), .DW(DW)) i_col_sample_ctrl_nxt (
        .clk(clk), .rst(rst), .dir_up(dir_up),
        .en_fwd_in(ro0), .en_rev_in(fo0),
        .en_fwd_out(fo1), .en_rev_out(ro1),
        .d_a(d_a), .d_b(d_b), .d_c(d_c), .samples(smp1));

    // {mid_en, dir, mul, off, base}
    localparam int NV = 6;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 1'b1, 6'd1,  6'd21, 6'd0 },
        {1'b0, 1'b0, 6'd1,  6'd21, 6'd5 },
        {1'b0, 1'b1, 6'd0,  6'd0,  6'd63},
        {1'b1, 1'b0, 6'd0,  6'd0,  6'd0 },
        {1'b1, 1'b1, 6'd5,  6'd13, 6'd3 },
        {1'b0, 1'b0, 6'd11, 6'd29, 6'd40}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] word(int g, int c, int mul, int off, int base);
        return DW'(g * mul + c * off + base);
    endfunction

    function automatic int slot_of(int j, bit dir);
        return dir ? (j - 1) : (SLOTS - j);
    endfunction

    task automatic cmp_store(input string req);
        int bad0 = 0, bad1 = 0, first = -1;
        for (int k = 0; k < SLOTS * 3; k++) begin
            if (smp0[k*DW +: DW] !== exp0[k]) begin bad0++; if (first < 0) first = k; end
            if (smp1[k*DW +: DW] !== exp1[k]) bad1++;
        end
        check(bad0 == 0, {req, " upstream store mismatches"}, bad0, 0);
        check(bad1 == 0, {req, " downstream store mismatches"}, bad1, 0);
    endtask

    task automatic clear_exp();
        for (int k = 0; k < SLOTS * 3; k++) begin exp0[k] = '0; exp1[k] = '0; end
    endtask

    task automatic drive_en(input bit dir, input bit v);
        if (dir) en_f0 = v; else en_r0 = v;
    endtask

    task automatic run_line(input logic [19:0] v);
        bit dir = v[18];
        bit mid = v[19];
        int mul = int'(v[17:12]), off = int'(v[11:6]), base = int'(v[5:0]);
        @(negedge clk);
        dir_up = dir;
        drive_en(dir, 1'b1);
        d_a = 6'h2A; d_b = 6'h15; d_c = 6'h3C;   // must not be written (R1)
        for (int g = 1; g <= 2 * SLOTS; g++) begin
            @(negedge clk);
            drive_en(dir, mid && (g == 40 || g == SLOTS));  // R7 extra enables
            if (g == SLOTS) begin
                check((dir ? ro0 : fo0) == 1'b1, "R5 hand-off high before last write", dir ? ro0 : fo0, 1);
                check((dir ? fo0 : ro0) == 1'b0, "R6 idle pin low", dir ? fo0 : ro0, 0);
            end
            if (g == SLOTS + 1)
                check((ro0 | fo0) == 1'b0, "R5 hand-off one period", ro0 | fo0, 0);
            if (g == 2 * SLOTS)
                check((dir ? ro1 : fo1) == 1'b1, "R9 downstream hand-off", dir ? ro1 : fo1, 1);
            d_a = word(g, 0, mul, off, base);
            d_b = word(g, 1, mul, off, base);
            d_c = word(g, 2, mul, off, base);
            for (int c = 0; c < 3; c++) begin
                if (g <= SLOTS) exp0[slot_of(g, dir) * 3 + c] = word(g, c, mul, off, base);
                else            exp1[slot_of(g - SLOTS, dir) * 3 + c] = word(g, c, mul, off, base);
            end
        end
        @(negedge clk);
        check((ro1 | fo1 | ro0 | fo0) == 1'b0, "R5 all hand-offs low after line", ro1 | fo1, 0);
        d_a = ~d_a; d_b = ~d_b; d_c = ~d_c;
        cmp_store(dir ? "R2 R4 R9 ascending" : "R2 R4 R9 descending");
        repeat (5) begin @(negedge clk); d_a = d_a + 6'd1; end
        cmp_store("R3 no writes in standby");
    endtask

    initial begin
        clear_exp();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(smp0 == '0 && smp1 == '0, "R8 store zero after reset", 0, 0);
        check({fo0, ro0, fo1, ro1} == 4'b0, "R8 hand-off low after reset", {fo0, ro0, fo1, ro1}, 0);

        for (int i = 0; i < NV; i++) run_line(VEC[i]);

        // R8: reset mid-line
        @(negedge clk);
        dir_up = 1'b1; en_f0 = 1'b1;
        @(negedge clk);
        en_f0 = 1'b0;
        repeat (10) begin @(negedge clk); d_a = d_a + 6'd3; end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        clear_exp();
        check(smp0 == '0 && smp1 == '0, "R8 mid-line reset clears store", 1, 0);
        check({fo0, ro0} == 2'b0, "R8 mid-line reset hand-off low", {fo0, ro0}, 0);
        repeat (100) begin @(negedge clk); d_b = d_b + 6'd7; end
        check(smp0 == '0, "R8 standby after reset, no writes", 1, 0);

        // R6: unused enable pin ignored
        dir_up = 1'b1;
        en_r0 = 1'b1;
        repeat (5) begin @(negedge clk); d_c = d_c + 6'd5; end
        en_r0 = 1'b0;
        repeat (3) @(negedge clk);
        check(smp0 == '0 && smp1 == '0, "R6 reverse input ignored when ascending", 1, 0);
        check({fo0, ro0} == 2'b0, "R6 no hand-off from ignored pin", {fo0, ro0}, 0);
        dir_up = 1'b0;
        en_f0 = 1'b1;
        repeat (5) begin @(negedge clk); d_a = d_a + 6'd9; end
        en_f0 = 1'b0;
        repeat (3) @(negedge clk);
        check(smp0 == '0 && smp1 == '0, "R6 forward input ignored when descending", 1, 0);

        // R1: one line after idle to confirm arm timing with ramp
        run_line({1'b0, 1'b1, 6'd3, 6'd7, 6'd1});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule